// File: doc/BRIEF.md
# Fetch Redirect Buffer with Branch Folding

This block sits beside the fetch stage. Each cycle the fetch address is compared against a small fully associative set of entries, each keyed by the address of a branch instruction seen earlier. On a match the block returns the branch's target as the next fetch address, so the redirect takes effect in the following cycle. On no match it returns the sequential address.

Each entry also carries a flag saying whether the branch always jumps, and a copy of the instruction found at its target. When a matching entry has that flag set, the block hands the stored target instruction to the pipeline in place of the branch. The branch is then removed from the instruction stream and costs no cycle.

Entries are written by the decode stage through one write port. A write whose branch address is already held updates that entry where it stands. A write for a new address takes the slot named by a rotating pointer. A one-cycle invalidate pulse empties the whole buffer.

Top module: `fetch_redirect_buf`

## Requirements
- R1: After a synchronous active-low reset, every entry is empty, so every lookup misses.
- R2: On a miss, `look_hit` and `look_fold` are low, `look_fold_insn` is zero, and `look_next_pc` equals `look_pc + INSN_BYTES`, where INSN_BYTES defaults to 4, modulo 2^PC_W.
- R3: When `look_pc` equals the branch address of a valid entry, `look_hit` is high and `look_next_pc` equals that entry's stored target.
- R4: On a hit, `look_fold` is high and `look_fold_insn` equals the stored target instruction only if the entry was written with `upd_always = 1`. For an entry written with `upd_always = 0`, `look_fold` is low and `look_fold_insn` is zero.
- R5: A write to an address not held in the buffer fills slots in the order 0, 1, ..., ENTRIES-1 and then wraps. Once all slots are full, each such write evicts the oldest allocation.
- R6: A write to an address already held in the buffer overwrites that entry's target, flag and instruction, and does not move the allocation pointer.
- R7: A cycle with `flush` high makes every lookup miss from the next cycle on. It also returns the allocation pointer to slot 0.
- R8: When `flush` and `upd_valid` are high in the same cycle, the write is dropped.
- R9: A lookup in the same cycle as a write to the same address returns the entry as it was before the write. The written contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| look_pc | input | PC_W | Current fetch address |
| look_hit | output | 1 | A valid entry matches `look_pc` |
| look_next_pc | output | PC_W | Stored target on a hit, otherwise the sequential address |
| look_fold | output | 1 | The hit entry is an always-taken branch; deliver the folded instruction |
| look_fold_insn | output | INSN_W | Instruction at the target when folding, otherwise zero |
| upd_valid | input | 1 | Write request from decode |
| upd_pc | input | PC_W | Branch instruction address to record |
| upd_target | input | PC_W | Branch target address |
| upd_always | input | 1 | 1 = branch always taken (fold-eligible), 0 = conditional |
| upd_insn | input | INSN_W | Instruction found at the target |
| flush | input | 1 | Empty every entry this cycle |

## Verification
Two pairs of functions can fall in the same cycle. The first is a lookup and a write to the same branch address. The bench provokes it by driving `look_pc` equal to `upd_pc` while the write is pending. It judges the result by expecting the old target before the clock edge and the new one after it. The second pair is a flush together with a write. There the bench expects the written address to miss afterwards, and it expects the next new allocation to land in slot 0. Both collisions also recur during a long pseudo-random stream of writes, lookups and flushes. In that stream every lookup is compared with a reference table the bench keeps from the requirements.

// File: rtl/frb_pkg.sv
// Shared definitions for the fetch redirect buffer.
// Assumes nothing beyond standard SystemVerilog.
package frb_pkg;
    // Branch kind held per entry; only ALWAYS entries are folded.
    typedef enum logic {
        BR_COND   = 1'b0,
        BR_ALWAYS = 1'b1
    } br_kind_e;
endpackage

// File: rtl/frb_store.sv
// Entry storage: valid bit, branch tag, target, kind and target instruction
// for each slot. One write per cycle, selected by a one-hot vector.
// Assumes wr_sel has at most one bit set; clear_all overrides any write.
module frb_store #(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 16,
    parameter int INSN_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_all,
    input  logic [ENTRIES-1:0]    wr_sel,
    input  logic [PC_W-1:0]       wr_tag,
    input  logic [PC_W-1:0]       wr_tgt,
    input  frb_pkg::br_kind_e     wr_kind,
    input  logic [INSN_W-1:0]     wr_insn,
    output logic [ENTRIES-1:0]    valid_o,
    output logic [PC_W-1:0]       tag_o  [ENTRIES],
    output logic [PC_W-1:0]       tgt_o  [ENTRIES],
    output frb_pkg::br_kind_e     kind_o [ENTRIES],
    output logic [INSN_W-1:0]     insn_o [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Valid bit: cleared on reset or flush, set on write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                valid_o[g] <= 1'b0;
            end else if (wr_sel[g]) begin
                valid_o[g] <= 1'b1;
            end
        end

        // Payload: loaded on write; no reset needed as valid guards it.
        always_ff @(posedge clk) begin
            if (wr_sel[g] && !clear_all) begin
                tag_o[g]  <= wr_tag;
                tgt_o[g]  <= wr_tgt;
                kind_o[g] <= wr_kind;
                insn_o[g] <= wr_insn;
            end
        end
    end
endmodule

// File: rtl/frb_match.sv
// Tag comparators: matches the lookup address and the write address against
// every valid entry. Assumes tags are unique among valid entries, so each
// output vector is at most one-hot.
module frb_match #(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 16
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [PC_W-1:0]    tag_i [ENTRIES],
    input  logic [PC_W-1:0]    look_pc,
    input  logic [PC_W-1:0]    upd_pc,
    output logic [ENTRIES-1:0] look_match,
    output logic [ENTRIES-1:0] upd_match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Compare both addresses against this slot's tag.
        always_comb begin
            look_match[g] = valid_i[g] && (tag_i[g] == look_pc);
            upd_match[g]  = valid_i[g] && (tag_i[g] == upd_pc);
        end
    end
endmodule

// File: rtl/frb_alloc.sv
// Slot selection for writes. A known tag is rewritten in place. A new tag
// goes to the rotating pointer, which then advances. A flush drops the
// write and rewinds the pointer to slot 0. Assumes ENTRIES >= 2.
module frb_alloc #(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic               flush,
    input  logic [ENTRIES-1:0] upd_match,
    output logic [ENTRIES-1:0] wr_sel
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic             known;
    logic             fresh;

    // Decide between in-place update and allocation at the pointer.
    always_comb begin
        known  = |upd_match;
        fresh  = upd_valid && !flush && !known;
        wr_sel = '0;
        if (upd_valid && !flush) begin
            if (known) begin
                wr_sel = upd_match;
            end else begin
                wr_sel[ptr_q] = 1'b1;
            end
        end
    end

    // Rotating replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (fresh) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/fetch_redirect_buf.sv
// Fetch redirect buffer: fully associative lookup of the fetch address against
// stored branch addresses. It returns the next fetch address and, for
// always-taken branches, the folded target instruction. Lookup is
// combinational from stored state, so a same-cycle write is seen one cycle
// later. Assumes the decode stage issues at most one write per cycle.
module fetch_redirect_buf #(
    parameter int ENTRIES    = 4,
    parameter int PC_W       = 16,
    parameter int INSN_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   look_pc,
    output logic              look_hit,
    output logic [PC_W-1:0]   look_next_pc,
    output logic              look_fold,
    output logic [INSN_W-1:0] look_fold_insn,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [PC_W-1:0]   upd_target,
    input  logic              upd_always,
    input  logic [INSN_W-1:0] upd_insn,
    input  logic              flush
);
    import frb_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic [ENTRIES-1:0] valid_v;
    logic [PC_W-1:0]    tag_v  [ENTRIES];
    logic [PC_W-1:0]    tgt_v  [ENTRIES];
    br_kind_e           kind_v [ENTRIES];
    logic [INSN_W-1:0]  insn_v [ENTRIES];
    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] upd_match;
    logic [ENTRIES-1:0] wr_sel;
    br_kind_e           upd_kind;
    logic [PC_W-1:0]    sel_tgt;
    logic [INSN_W-1:0]  sel_insn;
    logic               sel_always;

    // Map the write flag onto the stored kind.
    always_comb upd_kind = upd_always ? BR_ALWAYS : BR_COND;

    frb_store #(.ENTRIES(ENTRIES), .PC_W(PC_W), .INSN_W(INSN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (flush),
        .wr_sel    (wr_sel),
        .wr_tag    (upd_pc),
        .wr_tgt    (upd_target),
        .wr_kind   (upd_kind),
        .wr_insn   (upd_insn),
        .valid_o   (valid_v),
        .tag_o     (tag_v),
        .tgt_o     (tgt_v),
        .kind_o    (kind_v),
        .insn_o    (insn_v)
    );

    frb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_match (
        .valid_i    (valid_v),
        .tag_i      (tag_v),
        .look_pc    (look_pc),
        .upd_pc     (upd_pc),
        .look_match (look_match),
        .upd_match  (upd_match)
    );

    frb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .flush     (flush),
        .upd_match (upd_match),
        .wr_sel    (wr_sel)
    );

    // AND-OR read mux over the one-hot match vector.
    always_comb begin
        sel_tgt    = '0;
        sel_insn   = '0;
        sel_always = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) begin
                sel_tgt    = sel_tgt | tgt_v[i];
                sel_insn   = sel_insn | insn_v[i];
                sel_always = sel_always | (kind_v[i] == BR_ALWAYS);
            end
        end
    end

    // Next-address select and folding outputs.
    always_comb begin
        look_hit       = |look_match;
        look_next_pc   = look_hit ? sel_tgt : look_pc + STEP;
        look_fold      = look_hit && sel_always;
        look_fold_insn = look_fold ? sel_insn : '0;
    end
endmodule

// File: rtl/frb_checker.sv
// Property checker for the fetch redirect buffer, bound to every instance.
// Observes ports only.
module frb_checker #(
    parameter int PC_W   = 16,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   look_pc,
    input logic              look_hit,
    input logic [PC_W-1:0]   look_next_pc,
    input logic              look_fold,
    input logic [INSN_W-1:0] look_fold_insn,
    input logic              upd_valid,
    input logic [PC_W-1:0]   upd_pc,
    input logic [PC_W-1:0]   upd_target,
    input logic              flush
);
    // R1: the cycle after reset nothing hits.
    a_r1_empty_after_reset: assert property (@(posedge clk)
        !rst_n |=> !look_hit);

    // R4: folding only happens on a hit.
    a_r4_fold_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        look_fold |-> look_hit);

    // R7: after a flush every lookup misses.
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !look_hit);

    // R8: a write together with a flush leaves no entry behind.
    a_r8_flush_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && upd_valid) |=> !look_hit && !look_fold);

    // R3/R9: an accepted write is visible with its target on the next cycle.
    a_r9_write_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && !flush) && look_pc == $past(upd_pc))
        |-> (look_hit && look_next_pc == $past(upd_target)));
endmodule

bind fetch_redirect_buf frb_checker #(.PC_W(PC_W), .INSN_W(INSN_W)) u_frb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .look_pc        (look_pc),
    .look_hit       (look_hit),
    .look_next_pc   (look_next_pc),
    .look_fold      (look_fold),
    .look_fold_insn (look_fold_insn),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_target     (upd_target),
    .flush          (flush)
);

// File: tb/test_fetch_redirect_buf.sv
// Self-checking bench: directed corner cases plus a pseudo-random stream,
// compared against a table model kept from the requirements.
module test_fetch_redirect_buf;
    localparam int N  = 4;
    localparam int PW = 16;
    localparam int IW = 32;
    localparam int IB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] look_pc = '0;
    logic          look_hit;
    logic [PW-1:0] look_next_pc;
    logic          look_fold;
    logic [IW-1:0] look_fold_insn;
    logic          upd_valid = 1'b0;
    logic [PW-1:0] upd_pc = '0;
    logic [PW-1:0] upd_target = '0;
    logic          upd_always = 1'b0;
    logic [IW-1:0] upd_insn = '0;
    logic          flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference table
    bit            m_v   [N];
    logic [PW-1:0] m_tag [N];
    logic [PW-1:0] m_tgt [N];
    bit            m_al  [N];
    logic [IW-1:0] m_ins [N];
    int            m_ptr = 0;

    always #5 clk = ~clk;

    fetch_redirect_buf #(.ENTRIES(N), .PC_W(PW), .INSN_W(IW), .INSN_BYTES(IB)) i_fetch_redirect_buf (
        .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .look_hit(look_hit),
        .look_next_pc(look_next_pc), .look_fold(look_fold), .look_fold_insn(look_fold_insn),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_always(upd_always), .upd_insn(upd_insn), .flush(flush)
    );

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0;
    endtask

    task automatic model_write(input logic [PW-1:0] pc, input logic [PW-1:0] tgt,
                               input bit al, input logic [IW-1:0] ins);
        int slot = -1;
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) slot = i;
        if (slot < 0) begin
            slot  = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_v[slot] = 1; m_tag[slot] = pc; m_tgt[slot] = tgt; m_al[slot] = al; m_ins[slot] = ins;
    endtask

    task automatic expect1(input string req, input string what, input logic [IW-1:0] act,
                           input logic [IW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s pc=%h actual=%h expected=%h", req, what, look_pc, act, exp);
        end
    endtask

    // Compare outputs for the current look_pc against the model.
    task automatic check_look(input string note);
        bit            eh = 0;
        logic [PW-1:0] en;
        bit            ef = 0;
        logic [IW-1:0] ei = '0;
        string         req;
        en = look_pc + PW'(IB);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_tag[i] == look_pc) begin
                eh = 1; en = m_tgt[i]; ef = m_al[i];
                ei = m_al[i] ? m_ins[i] : '0;
            end
        end
        req = (note != "") ? note : (!eh ? "R2" : (ef ? "R4" : "R3"));
        expect1(req, "hit", IW'(look_hit), IW'(eh));
        expect1(req, "next_pc", IW'(look_next_pc), IW'(en));
        expect1(req, "fold", IW'(look_fold), IW'(ef));
        expect1(req, "fold_insn", look_fold_insn, ei);
    endtask

    // One cycle: drive at negedge, check lookup before the edge, update model after it.
    task automatic step(input bit wv, input logic [PW-1:0] wpc, input logic [PW-1:0] wt,
                        input bit wa, input logic [IW-1:0] wi, input bit fl,
                        input logic [PW-1:0] lpc, input string note);
        upd_valid = wv; upd_pc = wpc; upd_target = wt; upd_always = wa; upd_insn = wi;
        flush = fl; look_pc = lpc;
        #1;
        check_look(note);
        @(posedge clk);
        if (fl) model_clear();
        else if (wv) model_write(wpc, wt, wa, wi);
        @(negedge clk);
        upd_valid = 0; flush = 0;
    endtask

    task automatic wr(input logic [PW-1:0] pc, input logic [PW-1:0] t, input bit a,
                      input logic [IW-1:0] ins);
        step(1, pc, t, a, ins, 0, 16'h0ffc, "");
    endtask

    task automatic look(input logic [PW-1:0] pc, input string note);
        look_pc = pc; #1; check_look(note);
    endtask

    task automatic sweep(input string note);
        for (int p = 0; p < 16'h0400; p += 4) look(PW'(p), note);
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        #(1_500_000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, including the top address wrapping (R2).
        look(16'h0100, "R1");
        look(16'hfffc, "R2");
        expect1("R2", "wrap next_pc", IW'(look_next_pc), 32'h0000_0000);

        // Fill: slots 0..3; mix of always-taken and conditional.
        wr(16'h0100, 16'h1000, 1, 32'hA000_0001);
        wr(16'h0200, 16'h2000, 0, 32'hA000_0002);
        wr(16'h0300, 16'h3000, 1, 32'hA000_0003);
        wr(16'h0040, 16'h0800, 0, 32'hA000_0004);
        sweep("");                                   // R2 R3 R4

        // R5: fifth new tag evicts slot 0 (0x100).
        wr(16'h0104, 16'h4000, 1, 32'hA000_0005);
        look(16'h0100, "R5"); look(16'h0104, "R5"); look(16'h0200, "R5");

        // R6: update 0x300 in place (slot 2); pointer stays at slot 1.
        wr(16'h0300, 16'h3300, 0, 32'hB000_0003);
        look(16'h0300, "R6");
        wr(16'h0108, 16'h5000, 0, 32'hA000_0006);    // must evict 0x200 (slot 1)
        look(16'h0200, "R6"); look(16'h0300, "R6"); look(16'h0040, "R6");

        // R9: same-cycle lookup and write to one address.
        step(1, 16'h0104, 16'h6000, 0, 32'hC000_0000, 0, 16'h0104, "R9");
        look(16'h0104, "R9");

        // R7: flush empties everything and rewinds the pointer.
        step(0, '0, '0, 0, '0, 1, 16'h0040, "R7");
        sweep("R7");
        for (int k = 0; k < N + 1; k++)
            wr(PW'(16'h0200 + 4 * k), PW'(16'h7000 + 16 * k), k[0], IW'(k));
        look(16'h0200, "R7"); look(16'h0204, "R7"); look(16'h0210, "R7");

        // R8: flush and write together drop the write; pointer at 0 afterwards.
        step(1, 16'h0380, 16'h9000, 1, 32'hD000_0000, 1, 16'h0204, "R8");
        look(16'h0380, "R8");
        wr(16'h0390, 16'h9100, 1, 32'hD000_0001);
        for (int k = 1; k < N; k++) wr(PW'(16'h0390 + 4 * k), 16'h9200, 0, '0);
        wr(16'h03a0, 16'h9300, 0, '0);              // evicts 0x390 only if pointer was 0
        look(16'h0390, "R8"); look(16'h0394, "R8");

        // Pseudo-random stream with collisions (R3 R4 R5 R6 R9).
        for (int i = 0; i < 600; i++) begin
            logic [PW-1:0] wpc, lpc;
            wpc = PW'(((i * 37 + 11) % 12) * 4 + 16'h0040);
            lpc = (i % 5 == 0) ? wpc : PW'(((i * 13 + 3) % 14) * 4 + 16'h0040);
            step(i % 3 != 2, wpc, PW'(16'h1000 + i * 8), (i % 4) == 0, IW'(32'hE000_0000 + i),
                 (i % 97) == 96, lpc, "");
            look(lpc, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule